// File: doc/BRIEF.md
# Lockable NMI Trap Controller

This block turns an asynchronous, active-low non-maskable interrupt pin into a trap request for the CPU. The pin is brought into the clock domain by a chain of flip-flops. A high-to-low transition seen at the end of that chain is a candidate trap. The candidate becomes a trap only if one of two enable bits in a small control/status register is set.

The two enables behave differently. The one-shot arm bit permits a single trap and clears itself when that trap is taken, so a second edge cannot nest while the handler runs. The handler sets the arm bit again before it returns. The lock bit permits every edge to trap, and software cannot clear it. While the lock bit is set, the arm bit has no effect. Only reset clears the lock bit.

A taken trap sets a pending flag. The flag drives the request output and stays set until the CPU acknowledges it. Software can read the pending flag in the register.

Top module: `nmi_trap_ctl`

## Requirements
- R1: After reset, trap_req is 0 and rd_data reads 3'b000. In rd_data, bit 0 is the arm bit, bit 1 is the lock bit and bit 2 is the pending flag.
- R2: A falling edge on nmi_pin_n while the trap is enabled makes trap_req rise at the third rising clock edge after the first edge that samples the pin low. With the default two synchronizer stages, trap_req is still 0 after the second such edge. A pin held low, or a rising edge on the pin, raises no further trap.
- R3: A taken trap clears the arm bit (rd_data bit 0) at the same clock edge that raises trap_req. A later falling edge with only the arm bit set before that trap therefore raises no trap.
- R4: A falling edge that arrives while both the arm bit and the lock bit are 0 is discarded. Setting the arm bit afterwards does not raise a trap for that edge.
- R5: A write with wr_data bit 1 = 1 sets the lock bit. A write with bit 1 = 0 leaves the lock bit unchanged. The lock bit stays set across taken traps, and each enabled falling edge raises a trap.
- R6: While the lock bit is 1, the trap stays enabled even if the arm bit is written to 0.
- R7: trap_req stays 1 until trap_ack is sampled high. It then reads 0 after that clock edge, unless a new trap is taken at the same edge. rd_data bit 2 always equals trap_req.
- R8: If a new trap is taken at the same clock edge at which trap_ack is sampled high, trap_req stays 1.
- R9: wr_data bit 2 has no effect. Software cannot set or clear the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin_n | input | 1 | Raw asynchronous active-low interrupt pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: bit 0 arm, bit 1 lock, bit 2 ignored |
| rd_data | output | 3 | Register read: bit 0 arm, bit 1 lock, bit 2 pending |
| trap_req | output | 1 | Trap request to the CPU |
| trap_ack | input | 1 | Trap acknowledge from the CPU |

## Verification
An acknowledge of an outstanding request and a new trap can land on the same clock edge when the lock bit allows nesting. The bench provokes this by lowering the pin while a trap is still pending. It then holds trap_ack high during exactly the cycle in which the synchronized edge is detected. The request must still be high after that edge and must drop only at a later acknowledge. The bench also checks one more same-edge case: an edge taken while the lock bit is set clears the arm bit, and the lock bit stays set.

// File: rtl/nmi_trap_ctl.sv
module nmi_trap_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_pin_n,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic [2:0] rd_data,
  output logic       trap_req,
  input  logic       trap_ack
);

  localparam int PIPE = SYNC_STAGES + 1;

  logic [PIPE-1:0] pipe_q;
  logic            arm_q, lock_q, pend_q;
  logic            fall, take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[PIPE-2:0], nmi_pin_n};

  assign fall = pipe_q[PIPE-1] & ~pipe_q[PIPE-2];
  assign take = fall & (arm_q | lock_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     arm_q <= 1'b0;
    else if (take)  arm_q <= 1'b0;
    else if (wr_en) arm_q <= wr_data[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     lock_q <= 1'b0;
    else if (wr_en && wr_data[1])   lock_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pend_q <= 1'b0;
    else if (take)     pend_q <= 1'b1;
    else if (trap_ack) pend_q <= 1'b0;

  assign trap_req = pend_q;
  assign rd_data  = {pend_q, lock_q, arm_q};

endmodule

module nmi_trap_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       take,
  input logic       trap_req,
  input logic [2:0] rd_data
);

  p_take_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> trap_req);

  p_arm_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !rd_data[0]);

  p_rise_needs_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(take));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |=> rd_data[1]);

  p_req_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !ack) |=> trap_req);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !take) |=> !trap_req);

  p_ack_and_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && take) |=> trap_req);

endmodule

bind nmi_trap_ctl nmi_trap_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(trap_ack), .take(take),
  .trap_req(trap_req), .rd_data(rd_data)
);

// File: tb/nmi_trap_ctl_test.sv
module nmi_trap_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_pin_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic [2:0] rd_data;
  logic       trap_req;
  logic       trap_ack = 1'b0;

  typedef struct {
    string      tag;
    logic       req;
    logic [2:0] rd;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_trap_ctl uut (
    .clk(clk), .rst_n(rst_n), .nmi_pin_n(nmi_pin_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .trap_req(trap_req), .trap_ack(trap_ack)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag, input logic req, input logic [2:0] rd);
    exp_t e;
    #1;
    e.tag = tag; e.req = req; e.rd = rd;
    q.push_back(e);
  endtask

  task automatic write(input logic [2:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack_once();
    trap_ack = 1'b1;
    tick(1);
    trap_ack = 1'b0;
  endtask

  task automatic pin_high();
    nmi_pin_n = 1'b1;
    tick(4);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() != 0);
      e = q.pop_front();
      n_vec++;
      if (trap_req !== e.req || rd_data !== e.rd) begin
        n_bad++;
        $display("FAIL %s: req=%0b rd=%03b expected req=%0b rd=%03b",
                 e.tag, trap_req, rd_data, e.req, e.rd);
      end
    end
  end

  initial begin : driver
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_now("R1 reset state", 1'b0, 3'b000);

    nmi_pin_n = 1'b0; tick(5);
    expect_now("R4 edge while disabled", 1'b0, 3'b000);
    write(3'b001);
    tick(3);
    expect_now("R4 not remembered after arming", 1'b0, 3'b001);
    pin_high();
    expect_now("R2 rising edge no trap", 1'b0, 3'b001);

    nmi_pin_n = 1'b0; tick(2);
    expect_now("R2 not yet after two edges", 1'b0, 3'b001);
    tick(1);
    expect_now("R2 R3 trap raised, arm cleared", 1'b1, 3'b100);
    tick(5);
    expect_now("R7 request held, low level no retrigger", 1'b1, 3'b100);
    write(3'b100);
    expect_now("R9 pending not writable", 1'b1, 3'b100);
    ack_once();
    expect_now("R7 ack clears request", 1'b0, 3'b000);
    write(3'b100);
    expect_now("R9 pending cannot be set", 1'b0, 3'b000);

    pin_high();
    nmi_pin_n = 1'b0; tick(5);
    expect_now("R3 one-shot blocks next edge", 1'b0, 3'b000);
    pin_high();

    write(3'b010);
    expect_now("R5 lock set", 1'b0, 3'b010);
    write(3'b000);
    expect_now("R5 lock not clearable", 1'b0, 3'b010);
    write(3'b011);
    write(3'b010);
    expect_now("R6 arm cleared under lock", 1'b0, 3'b010);
    nmi_pin_n = 1'b0; tick(3);
    expect_now("R6 lock traps with arm 0", 1'b1, 3'b110);
    ack_once();
    expect_now("R7 ack under lock", 1'b0, 3'b010);
    pin_high();

    write(3'b011);
    nmi_pin_n = 1'b0; tick(3);
    expect_now("R5 lock trap clears arm, keeps lock", 1'b1, 3'b110);
    pin_high();
    nmi_pin_n = 1'b0; tick(2);
    trap_ack = 1'b1; tick(1); trap_ack = 1'b0;
    expect_now("R8 ack and new trap same edge", 1'b1, 3'b110);
    ack_once();
    expect_now("R8 later ack clears", 1'b0, 3'b010);

    pin_high();
    nmi_pin_n = 1'b0; tick(3);
    expect_now("R5 every edge traps while locked", 1'b1, 3'b110);
    ack_once();
    pin_high();
    expect_now("R2 rising edge no trap under lock", 1'b0, 3'b010);

    wait (q.size() == 0);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule